// File: doc/BRIEF.md
# Spread-FSK Tone Modulator

This block produces the digital carrier for a power-line transmitter that uses spread frequency-shift keying. Each data bit picks one of two tones that are programmed on their own and placed far apart, so that each tone fades and picks up noise on its own. A zero bit is sent on the space tone and a one bit on the mark tone. A phase accumulator advances by the tuning word of the selected tone on every clock. The top bits of the phase index a quarter-wave sine table, and symmetry turns that table into a full signed cycle. The signed samples go to an external DAC, together with a flag that marks each valid sample.

Tone frequency is `tw * f_clk / 2**PHASE_W`. A carrier between roughly 9 kHz and 95 kHz is set by choosing the word for the system clock in use. The usual gap between the two tones is about 10 kHz. The accumulator keeps running through bit boundaries, so the waveform has no phase steps.

A compliance test mode broadcasts one tone without a break. A select input picks the tone, and the data bits are ignored. Tuning words may be written at any time, but they only take effect while the transmitter is idle.

Top module: `sfsk_tone_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `smp_out` is 0 and `smp_vld` is 0.
- R2: When `tx_en` and `tst_en` are both low at a clock edge, the next output is `smp_out`=0 with `smp_vld`=0, and the phase returns to 0. The first sample of the next run is therefore taken at phase 0.
- R3: In data mode, bit 0 advances the phase by the space word and bit 1 advances it by the mark word. `bit_in` is taken when `bit_stb`=1 and is used from that same edge until the next strobe.
- R4: A change of bit does not reset the phase. The new step is added to the accumulated phase, so the sample sequence stays continuous.
- R5: Let p be the top 8 bits of the phase before the edge. While running, each edge outputs round(511*sin(2*pi*(p+0.5)/256)) within 2 LSB, with `smp_vld`=1, one cycle after the phase that it encodes.
- R6: When `tst_en`=1, the block transmits whatever the value of `tx_en`. It uses the mark word if `tst_sel`=1 and the space word if `tst_sel`=0, and `bit_stb`/`bit_in` have no effect.
- R7: A pulse on `tw_wr` while idle loads `tw_space`/`tw_mark` into the active words at that edge, so the next run uses them.
- R8: A pulse on `tw_wr` while running does not change the active words. The last such write is applied at the first idle edge.
- R9: After reset, the active words are the parameters `DEF_SPACE` and `DEF_MARK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit phase active |
| tst_en | input | 1 | Continuous single-tone test mode |
| tst_sel | input | 1 | Test tone select, 1 = mark, 0 = space |
| bit_stb | input | 1 | Strobe for `bit_in` |
| bit_in | input | 1 | Serial data bit |
| tw_wr | input | 1 | Tuning word write pulse |
| tw_space | input | PHASE_W | Space tone phase step |
| tw_mark | input | PHASE_W | Mark tone phase step |
| smp_out | output | SAMPLE_W | Signed sine sample |
| smp_vld | output | 1 | Sample valid |

## Verification
Two sets of events can land in one cycle.

The first is a tuning write arriving in the same cycle that transmit enable falls. That edge is idle, so the write must load at once. A write held from the run must not take its place.

The second is a bit strobe arriving while test mode is on. Test mode must take priority, and the stored data bit must still change for later data-mode use.

Both cases are driven on purpose. The scoreboard judges them by the phase steps it sees in the sample stream that follows, and it compares every sample against a model built from the sine formula.

// File: rtl/sfsk_pkg.sv
package sfsk_pkg;

  // Quarter-wave entry i of a table with 2**qbits points per quarter,
  // centred half a step into each slot so both mirror halves share it.
  // Rational sine approximation, integer only, rounded to nearest.
  function automatic int quarter_sine(input int i, input int qbits, input int amp);
    longint half;
    longint x;
    longint p;
    longint num;
    longint den;
    half = longint'(1) << (qbits + 2);
    x    = 2 * longint'(i) + 1;
    p    = x * (half - x);
    num  = longint'(amp) * 16 * p;
    den  = 5 * half * half - 4 * p;
    return int'((num + den / 2) / den);
  endfunction

  // Table address from a phase index: mirror on odd quadrants.
  function automatic int unsigned mirror_addr(input int unsigned idx,
                                              input bit odd_quad,
                                              input int qbits);
    int unsigned mask;
    mask = (1 << qbits) - 1;
    return odd_quad ? (mask - (idx & mask)) : (idx & mask);
  endfunction

endpackage

// File: rtl/sfsk_tune_bank.sv
module sfsk_tune_bank #(
  parameter int PHASE_W = 24,
  parameter logic [PHASE_W-1:0] DEF_SPACE = '0,
  parameter logic [PHASE_W-1:0] DEF_MARK  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle,
  input  logic               wr,
  input  logic [PHASE_W-1:0] space_in,
  input  logic [PHASE_W-1:0] mark_in,
  output logic [PHASE_W-1:0] space_q,
  output logic [PHASE_W-1:0] mark_q,
  output logic               pend_q
);

  logic [PHASE_W-1:0] pend_space;
  logic [PHASE_W-1:0] pend_mark;
  logic               load_direct;
  logic               load_held;
  logic               hold_new;

  assign load_direct = idle & wr;
  assign load_held   = idle & ~wr & pend_q;
  assign hold_new    = ~idle & wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q    <= DEF_SPACE;
      mark_q     <= DEF_MARK;
      pend_space <= '0;
      pend_mark  <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (load_direct) begin
        space_q <= space_in;
        mark_q  <= mark_in;
        pend_q  <= 1'b0;
      end else if (load_held) begin
        space_q <= pend_space;
        mark_q  <= pend_mark;
        pend_q  <= 1'b0;
      end else if (hold_new) begin
        pend_space <= space_in;
        pend_mark  <= mark_in;
        pend_q     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sfsk_phase_acc.sv
module sfsk_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tst_en,
  input  logic               tst_sel,
  input  logic               bit_stb,
  input  logic               bit_in,
  input  logic [PHASE_W-1:0] space_w,
  input  logic [PHASE_W-1:0] mark_w,
  output logic               sel_mark,
  output logic [PHASE_W-1:0] acc_q
);

  logic               bit_q;
  logic               data_sel;
  logic [PHASE_W-1:0] step;

  // A strobed bit steers the step at the same edge it is stored.
  assign data_sel = bit_stb ? bit_in : bit_q;
  assign sel_mark = tst_en ? tst_sel : data_sel;
  assign step     = sel_mark ? mark_w : space_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (bit_stb) begin
      bit_q <= bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (run) begin
      acc_q <= acc_q + step;
    end else begin
      acc_q <= '0;
    end
  end

endmodule

// File: rtl/sfsk_sine_rom.sv
module sfsk_sine_rom #(
  parameter int SAMPLE_W = 10,
  parameter int LUT_AW   = 6
) (
  input  logic [LUT_AW+1:0]          phase,
  output logic signed [SAMPLE_W-1:0] sample
);
  import sfsk_pkg::*;

  localparam int DEPTH = 1 << LUT_AW;
  localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

  logic [SAMPLE_W-2:0] tbl [DEPTH];
  logic [1:0]          quad;
  logic [LUT_AW-1:0]   idx;
  logic [LUT_AW-1:0]   addr;
  logic [SAMPLE_W-1:0] mag;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = (SAMPLE_W-1)'(quarter_sine(g, LUT_AW, AMP));
  end

  assign quad = phase[LUT_AW+1:LUT_AW];
  assign idx  = phase[LUT_AW-1:0];
  assign addr = LUT_AW'(mirror_addr(32'(idx), quad[0], LUT_AW));
  assign mag  = {1'b0, tbl[addr]};

  always_comb begin
    if (quad[1]) begin
      sample = -$signed(mag);
    end else begin
      sample = $signed(mag);
    end
  end

endmodule

// File: rtl/sfsk_tone_gen.sv
module sfsk_tone_gen #(
  parameter int PHASE_W  = 24,
  parameter int SAMPLE_W = 10,
  parameter int LUT_AW   = 6,
  parameter logic [PHASE_W-1:0] DEF_SPACE = 24'h050000,
  parameter logic [PHASE_W-1:0] DEF_MARK  = 24'h0B3000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_en,
  input  logic                       tst_en,
  input  logic                       tst_sel,
  input  logic                       bit_stb,
  input  logic                       bit_in,
  input  logic                       tw_wr,
  input  logic [PHASE_W-1:0]         tw_space,
  input  logic [PHASE_W-1:0]         tw_mark,
  output logic signed [SAMPLE_W-1:0] smp_out,
  output logic                       smp_vld
);

  localparam int IDX_W = LUT_AW + 2;

  // Named internal events, visible to the bound checker.
  logic                       busy;
  logic                       sel_mark;
  logic                       pend_vld;
  logic [PHASE_W-1:0]         act_space;
  logic [PHASE_W-1:0]         act_mark;
  logic [PHASE_W-1:0]         acc;
  logic [IDX_W-1:0]           phase_idx;
  logic signed [SAMPLE_W-1:0] rom_smp;

  assign busy      = tx_en | tst_en;
  assign phase_idx = acc[PHASE_W-1 -: IDX_W];

  sfsk_tune_bank #(
    .PHASE_W  (PHASE_W),
    .DEF_SPACE(DEF_SPACE),
    .DEF_MARK (DEF_MARK)
  ) u_tune (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (~busy),
    .wr      (tw_wr),
    .space_in(tw_space),
    .mark_in (tw_mark),
    .space_q (act_space),
    .mark_q  (act_mark),
    .pend_q  (pend_vld)
  );

  sfsk_phase_acc #(
    .PHASE_W(PHASE_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .tst_en  (tst_en),
    .tst_sel (tst_sel),
    .bit_stb (bit_stb),
    .bit_in  (bit_in),
    .space_w (act_space),
    .mark_w  (act_mark),
    .sel_mark(sel_mark),
    .acc_q   (acc)
  );

  sfsk_sine_rom #(
    .SAMPLE_W(SAMPLE_W),
    .LUT_AW  (LUT_AW)
  ) u_rom (
    .phase (phase_idx),
    .sample(rom_smp)
  );

  // Sample the phase held before this edge's advance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_out <= '0;
      smp_vld <= 1'b0;
    end else begin
      smp_out <= busy ? rom_smp : '0;
      smp_vld <= busy;
    end
  end

endmodule

// File: rtl/sfsk_tone_chk.sv
module sfsk_tone_chk #(
  parameter int PHASE_W  = 24,
  parameter int SAMPLE_W = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tx_en,
  input logic                       tst_en,
  input logic                       tst_sel,
  input logic                       bit_stb,
  input logic                       bit_in,
  input logic                       tw_wr,
  input logic [PHASE_W-1:0]         tw_space,
  input logic                       busy,
  input logic [PHASE_W-1:0]         acc,
  input logic [PHASE_W-1:0]         act_space,
  input logic [PHASE_W-1:0]         act_mark,
  input logic signed [SAMPLE_W-1:0] smp_out,
  input logic                       smp_vld
);

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (smp_out == '0) && !smp_vld); // R2

  AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> acc == '0); // R2

  AST_RUN_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> smp_vld); // R5

  AST_PHASE_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tst_en && bit_stb) |=>
      acc == $past(acc) + ($past(bit_in) ? $past(act_mark) : $past(act_space))); // R4

  AST_TEST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_en && tst_sel) |=> acc == $past(acc) + $past(act_mark)); // R6

  AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(act_space) && $stable(act_mark)); // R8

  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tw_wr) |=> act_space == $past(tw_space)); // R7

endmodule

bind sfsk_tone_gen sfsk_tone_chk #(
  .PHASE_W (PHASE_W),
  .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .tst_en   (tst_en),
  .tst_sel  (tst_sel),
  .bit_stb  (bit_stb),
  .bit_in   (bit_in),
  .tw_wr    (tw_wr),
  .tw_space (tw_space),
  .busy     (busy),
  .acc      (acc),
  .act_space(act_space),
  .act_mark (act_mark),
  .smp_out  (smp_out),
  .smp_vld  (smp_vld)
);

// File: tb/sim_sfsk_tone_gen.sv
module sim_sfsk_tone_gen;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 24;
  localparam int SW = 10;
  localparam logic [PW-1:0] D_SPACE = 24'h050000;
  localparam logic [PW-1:0] D_MARK  = 24'h0B3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, tst_en = 1'b0, tst_sel = 1'b0;
  logic bit_stb = 1'b0, bit_in = 1'b0, tw_wr = 1'b0;
  logic [PW-1:0] tw_space = '0, tw_mark = '0;
  logic signed [SW-1:0] smp_out;
  logic smp_vld;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  typedef struct {
    bit    vld;
    int    val;
    string req;
  } exp_t;
  exp_t sbq[$];

  sfsk_tone_gen #(
    .PHASE_W(PW), .SAMPLE_W(SW), .LUT_AW(6),
    .DEF_SPACE(D_SPACE), .DEF_MARK(D_MARK)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tst_en(tst_en),
    .tst_sel(tst_sel), .bit_stb(bit_stb), .bit_in(bit_in),
    .tw_wr(tw_wr), .tw_space(tw_space), .tw_mark(tw_mark),
    .smp_out(smp_out), .smp_vld(smp_vld)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  // Reference sine straight from the requirement formula.
  function automatic int ref_sine(input logic [PW-1:0] ph);
    real a;
    real s;
    a = 2.0 * 3.14159265358979 * (real'(ph[PW-1 -: 8]) + 0.5) / 256.0;
    s = 511.0 * $sin(a);
    return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
  endfunction

  // Reference model state.
  logic [PW-1:0] m_acc, m_as, m_am, m_ps, m_pm;
  logic m_bit, m_pf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0; m_as = D_SPACE; m_am = D_MARK;
      m_ps = '0; m_pm = '0; m_bit = 1'b0; m_pf = 1'b0;
    end else begin
      bit run;
      bit mk;
      exp_t e;
      run = tx_en | tst_en;
      mk  = tst_en ? tst_sel : (bit_stb ? bit_in : m_bit);
      e.vld = run;
      e.val = run ? ref_sine(m_acc) : 0;
      e.req = cur_req;
      sbq.push_back(e);
      m_acc = run ? m_acc + (mk ? m_am : m_as) : '0;
      if (bit_stb) m_bit = bit_in;
      if (!run && tw_wr) begin
        m_as = tw_space; m_am = tw_mark; m_pf = 1'b0;
      end else if (!run && m_pf) begin
        m_as = m_ps; m_am = m_pm; m_pf = 1'b0;
      end else if (tw_wr) begin
        m_ps = tw_space; m_pm = tw_mark; m_pf = 1'b1;
      end
    end
  end

  // Monitor: pop and compare away from the active edge.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      int d;
      e = sbq.pop_front();
      d = int'(smp_out) - e.val;
      n_chk++;
      if (smp_vld !== e.vld || d > 2 || d < -2) begin
        n_bad++;
        $display("FAIL %s: sample=%0d vld=%0b expected=%0d vld=%0b",
                 e.req, smp_out, smp_vld, e.val, e.vld);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int len);
    @(negedge clk); bit_stb = 1'b1; bit_in = b;
    @(negedge clk); bit_stb = 1'b0;
    cyc(len - 1);
  endtask

  task automatic write_tw(input logic [PW-1:0] s, input logic [PW-1:0] m);
    @(negedge clk); tw_wr = 1'b1; tw_space = s; tw_mark = m;
    @(negedge clk); tw_wr = 1'b0;
  endtask

  task automatic direct_check(input string req, input bit cond,
                              input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(3);
    direct_check("R1", smp_out == 0 && smp_vld == 0, int'(smp_out), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);
    direct_check("R1", smp_out == 0 && smp_vld == 0, int'(smp_out), 0);

    // R9: default words drive the first run (space tone, bit 0)
    cur_req = "R9";
    @(negedge clk); tx_en = 1'b1;
    cyc(20);
    send_bit(1'b1, 10);

    // R2: idle zeroes output and phase
    cur_req = "R2";
    @(negedge clk); tx_en = 1'b0;
    cyc(4);
    @(negedge clk); tx_en = 1'b1;
    cyc(6);

    // R3: data bits pick space/mark
    cur_req = "R3";
    send_bit(1'b1, 7); send_bit(1'b0, 7); send_bit(1'b1, 5);
    send_bit(1'b1, 5); send_bit(1'b0, 9);

    // R4: quick alternation keeps phase continuous
    cur_req = "R4";
    for (int i = 0; i < 24; i++) send_bit(((i * 5) % 3) == 1, 2 + (i % 3));

    // R5: one table point per cycle sweeps every entry
    cur_req = "R5";
    @(negedge clk); tx_en = 1'b0;
    write_tw(24'h010000, 24'h020000);
    @(negedge clk); tx_en = 1'b1; bit_stb = 1'b1; bit_in = 1'b0;
    @(negedge clk); bit_stb = 1'b0;
    cyc(260);
    send_bit(1'b1, 140);

    // R6: test mode, data strobes ignored, tx_en irrelevant
    cur_req = "R6";
    @(negedge clk); tx_en = 1'b0;
    write_tw(24'h061000, 24'h0D2000);
    @(negedge clk); tst_en = 1'b1; tst_sel = 1'b1;
    for (int i = 0; i < 6; i++) send_bit(i[0], 4);
    @(negedge clk); tst_sel = 1'b0;
    for (int i = 0; i < 6; i++) send_bit(~i[0], 4);
    @(negedge clk); tx_en = 1'b1; tst_sel = 1'b1;
    send_bit(1'b0, 10);
    @(negedge clk); tst_en = 1'b0;
    cyc(10);

    // R7: idle write takes effect for next run
    cur_req = "R7";
    @(negedge clk); tx_en = 1'b0;
    write_tw(24'h033000, 24'h0A7000);
    @(negedge clk); tx_en = 1'b1;
    send_bit(1'b0, 8); send_bit(1'b1, 8);

    // R8: writes while running are held, last one wins
    cur_req = "R8";
    write_tw(24'h0F0000, 24'h0F0000);
    cyc(5);
    write_tw(24'h044000, 24'h0C8000);
    send_bit(1'b0, 8); send_bit(1'b1, 8);
    @(negedge clk); tx_en = 1'b0;
    cyc(2);
    @(negedge clk); tx_en = 1'b1;
    send_bit(1'b0, 8); send_bit(1'b1, 8);

    // R8: write in the same cycle tx_en falls loads at once
    write_tw(24'h0E0000, 24'h0E0000);
    @(negedge clk); tx_en = 1'b0; tw_wr = 1'b1;
    tw_space = 24'h028000; tw_mark = 24'h090000;
    @(negedge clk); tw_wr = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    send_bit(1'b0, 8); send_bit(1'b1, 8);
    @(negedge clk); tx_en = 1'b0;
    cyc(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule